// File: doc/BRIEF.md
# Cascadable Synchronous Nibble Counter

This block is a 12-bit synchronous up-counter built from three identical 4-bit counter slices. Each slice has two count enables and a carry output, so the slices chain without a long ripple path. A slice advances only when both of its enables are high. Its carry output needs only the second enable, together with the slice being at all ones. In the chain, the least significant slice takes both enables from the block inputs. Each higher slice takes the shared first enable from the block input and its second enable from the carry of the slice below it.

A mode input turns the lowest slice into a modulo-12 counter. In that mode the low slice reloads zero after it reaches eleven, so it passes through twelve states. A terminal output marks the state eleven.

A synchronous active-low clear and a synchronous active-low parallel load act on all slices at once. Every state change happens on the rising clock edge.

Top module: `chained_nibble_counter`

## Requirements
- R1: On a rising edge with clear and load both inactive (high), and with en_p and en_t both high, the 12-bit count increases by exactly one, and all bits change on that same edge.
- R2: If en_p or en_t is low, and clear and load are inactive, the count keeps its value across the edge.
- R3: carry_out is combinational and equals en_t AND all 12 count bits being 1. It changes at once when en_t changes, without waiting for a clock edge.
- R4: Slice k (bits 4k+3..4k, k>0) changes on a counting edge only when every count bit below bit 4k is 1.
- R5: The count sequence is plain binary, and 0xFFF followed by a counting edge gives 0x000.
- R6: A low clr_n sets the count to 0 on the next edge whatever load_n and the enables are. Otherwise, a low load_n copies load_val into the count on the next edge whatever the enables are.
- R7: When div12_en is 1 and the low 4 bits are 1011 (decimal 11), a counting edge sets the low 4 bits to 0000 and leaves bits 11..4 unchanged. Continuous counting from 0 therefore repeats a 12-state cycle.
- R8: term_pulse is 1 exactly when div12_en is 1 and count[3:0] is 1011. During continuous counting it is a one-cycle pulse in every 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| load_val | input | 12 | Value copied into the count on a load |
| en_p | input | 1 | Shared count enable for every slice |
| en_t | input | 1 | Second enable of the low slice; it also qualifies the carry |
| div12_en | input | 1 | Makes the low slice a modulo-12 counter |
| count | output | 12 | Counter value |
| carry_out | output | 1 | Carry of the top slice |
| term_pulse | output | 1 | Marks state eleven of the low slice in modulo-12 mode |

## Verification
The long random run holds en_t high and toggles en_p at random. Comparing the count against a plain integer model shows whether a slice steps without its lower bits being all ones, or fails to step when they are. Loads just below 0xFFF, with en_t toggled, separate a carry that is qualified by en_t from one that is not, and they exercise the wrap. Clear, load and the enables asserted together show the priority order. A modulo-12 run from zero shows whether the reload happens at eleven, a cycle early or a cycle late, and whether it disturbs the upper slices.

// File: rtl/nibctr_pkg.sv
package nibctr_pkg;
  localparam int NIB_W  = 4;
  localparam int MOD12_TERM = 11;

  function automatic logic [NIB_W-1:0] nib_next(input logic [NIB_W-1:0] q);
    return q + NIB_W'(1);
  endfunction

  function automatic logic nib_full(input logic [NIB_W-1:0] q);
    return &q;
  endfunction
endpackage

// File: rtl/nibble_counter.sv
module nibble_counter
  import nibctr_pkg::*;
(
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [NIB_W-1:0] din,
  input  logic             en_p,
  input  logic             en_t,
  output logic [NIB_W-1:0] q,
  output logic             rco
);
  logic step_ev;
  assign step_ev = en_p & en_t;

  always_ff @(posedge clk) begin
    if (!clr_n)       q <= '0;
    else if (!load_n) q <= din;
    else if (step_ev) q <= nib_next(q);
  end

  assign rco = nib_full(q) & en_t;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !step_ev) |=> $stable(q)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && step_ev) |=> (q == NIB_W'($past(q) + 1))); // R1
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!clr_n)
    (!load_n) |=> (q == $past(din))); // R6
  AST_CLEAR_ZERO: assert property (@(posedge clk)
    (!clr_n) |=> (q == '0)); // R6
endmodule

// File: rtl/mod12_ctrl.sv
module mod12_ctrl
  import nibctr_pkg::*;
(
  input  logic             clk,
  input  logic             clr_n,
  input  logic             mode,
  input  logic [NIB_W-1:0] low_q,
  input  logic             step_ev,
  input  logic             ext_load_n,
  input  logic [NIB_W-1:0] ext_din,
  output logic             load_n_eff,
  output logic [NIB_W-1:0] din_eff,
  output logic             term
);
  localparam logic [NIB_W-1:0] TERM_V = NIB_W'(MOD12_TERM);

  logic at_term;
  logic fb_load;

  assign at_term    = (low_q == TERM_V);
  assign fb_load    = mode & at_term & step_ev;
  assign load_n_eff = ext_load_n & ~fb_load;
  assign din_eff    = ext_load_n ? '0 : ext_din;
  assign term       = mode & at_term;

  AST_MOD12_WRAP: assert property (@(posedge clk) disable iff (!clr_n)
    (ext_load_n && fb_load) |=> (low_q == '0)); // R7
endmodule

// File: rtl/chained_nibble_counter.sv
module chained_nibble_counter
  import nibctr_pkg::*;
#(
  parameter int NIBBLES = 3,
  localparam int CW = NIBBLES * NIB_W
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          load_n,
  input  logic [CW-1:0] load_val,
  input  logic          en_p,
  input  logic          en_t,
  input  logic          div12_en,
  output logic [CW-1:0] count,
  output logic          carry_out,
  output logic          term_pulse
);
  logic [NIBBLES-1:0] rco_chain;
  logic [NIBBLES-1:0] t_chain;
  logic               low_load_n;
  logic [NIB_W-1:0]   low_din;

  mod12_ctrl u_mod12 (
    .clk        (clk),
    .clr_n      (clr_n),
    .mode       (div12_en),
    .low_q      (count[NIB_W-1:0]),
    .step_ev    (en_p & en_t),
    .ext_load_n (load_n),
    .ext_din    (load_val[NIB_W-1:0]),
    .load_n_eff (low_load_n),
    .din_eff    (low_din),
    .term       (term_pulse)
  );

  for (genvar g = 0; g < NIBBLES; g++) begin : g_nib
    if (g == 0) begin : g_low
      assign t_chain[g] = en_t;
      nibble_counter u_nib (
        .clk (clk), .clr_n (clr_n), .load_n (low_load_n), .din (low_din),
        .en_p (en_p), .en_t (t_chain[g]),
        .q (count[NIB_W-1:0]), .rco (rco_chain[g])
      );
    end else begin : g_high
      assign t_chain[g] = rco_chain[g-1];
      nibble_counter u_nib (
        .clk (clk), .clr_n (clr_n), .load_n (load_n),
        .din (load_val[g*NIB_W +: NIB_W]),
        .en_p (en_p), .en_t (t_chain[g]),
        .q (count[g*NIB_W +: NIB_W]), .rco (rco_chain[g])
      );

      AST_CHAIN_GATE: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(&count[g*NIB_W-1:0])) |=> $stable(count[g*NIB_W +: NIB_W])); // R4
    end
  end

  assign carry_out = rco_chain[NIBBLES-1];

  AST_CARRY_LOW: assert property (@(posedge clk) disable iff (!clr_n)
    (!en_t) |-> !carry_out); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t && !div12_en && (&count)) |=> (count == '0)); // R5
endmodule

// File: tb/sim_chained_nibble_counter.sv
`timescale 1ns/1ps
module sim_chained_nibble_counter;
  logic        clk = 1'b0;
  logic        clr_n = 1'b0, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0, div12_en = 1'b0;
  logic [11:0] load_val = '0;
  logic [11:0] count;
  logic        carry_out, term_pulse;

  always #2 clk = ~clk;

  chained_nibble_counter u0 (
    .clk (clk), .clr_n (clr_n), .load_n (load_n), .load_val (load_val),
    .en_p (en_p), .en_t (en_t), .div12_en (div12_en),
    .count (count), .carry_out (carry_out), .term_pulse (term_pulse)
  );

  int checks = 0, fails = 0;
  logic [11:0] ref_cnt = '0;
  logic [15:0] sb_q[$];
  logic [11:0] prev_cnt = '0;
  bit done = 0;

  task automatic note(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic drive(input bit c, input bit l, input logic [11:0] v,
                       input bit p, input bit t, input bit m);
    bit plain;
    @(negedge clk);
    clr_n = c; load_n = l; load_val = v; en_p = p; en_t = t; div12_en = m;
    plain = c && l;
    if (!c)          ref_cnt = '0;
    else if (!l)     ref_cnt = v;
    else if (p && t) begin
      if (m && ref_cnt[3:0] == 4'd11) ref_cnt = {ref_cnt[11:4], 4'd0};
      else                            ref_cnt = ref_cnt + 12'd1;
    end
    sb_q.push_back({1'b0, plain, ref_cnt, (&ref_cnt) & t, m && ref_cnt[3:0] == 4'd11});
  endtask

  // monitor: compares each edge's result against the queued expectation
  initial begin
    forever begin
      @(posedge clk); #1;
      if (sb_q.size() > 0) begin
        logic [15:0] e;
        e = sb_q.pop_front();
        note(count == e[13:2], "R1/R2/R5/R6/R7 count", count, e[13:2]);
        note(carry_out == e[1], "R3 carry", carry_out, e[1]);
        note(term_pulse == e[0], "R8 term", term_pulse, e[0]);
        if (e[14]) begin
          if (prev_cnt[3:0] != 4'hF)
            note(count[11:4] == prev_cnt[11:4], "R4 slice1 gate", count[11:4], prev_cnt[11:4]);
          if (prev_cnt[7:0] != 8'hFF)
            note(count[11:8] == prev_cnt[11:8], "R4 slice2 gate", count[11:8], prev_cnt[11:8]);
        end
        prev_cnt = count;
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // reset state
    drive(0, 1, 12'h000, 0, 0, 0);
    drive(0, 1, 12'h000, 0, 0, 0);
    // R6: clear beats load and enables
    drive(0, 0, 12'hABC, 1, 1, 0);
    // R6: load beats counting
    drive(1, 0, 12'h3C5, 1, 1, 0);
    // R2: hold with each enable low
    drive(1, 1, 12'h000, 0, 1, 0);
    drive(1, 1, 12'h000, 1, 0, 0);
    // R1: plain counting
    for (int i = 0; i < 20; i++) drive(1, 1, 12'h000, 1, 1, 0);
    // R5 and R3: wrap at 0xFFF, carry qualified by en_t
    drive(1, 0, 12'hFFD, 0, 0, 0);
    drive(1, 1, 12'h000, 1, 1, 0);
    drive(1, 1, 12'h000, 1, 1, 0);
    drive(1, 1, 12'h000, 0, 0, 0);   // at FFF, en_t low: carry 0
    drive(1, 1, 12'h000, 0, 1, 0);   // R3 at FFF, en_t high, no step: carry 1
    drive(1, 1, 12'h000, 1, 1, 0);   // R5 wrap to 000
    // R4: crossing slice boundaries
    drive(1, 0, 12'h0FE, 0, 0, 0);
    for (int i = 0; i < 4; i++) drive(1, 1, 12'h000, 1, 1, 0);
    // R7 and R8: modulo-12 from zero with nonzero upper bits
    drive(1, 0, 12'h520, 0, 0, 1);
    for (int i = 0; i < 30; i++) drive(1, 1, 12'h000, 1, 1, 1);
    drive(1, 1, 12'h000, 0, 1, 1);
    // R1/R2/R4: long random run with en_p toggling
    drive(0, 1, 12'h000, 0, 0, 0);
    for (int i = 0; i < 5000; i++) drive(1, 1, 12'h000, 1'($urandom), 1, 0);
    for (int i = 0; i < 300; i++) drive(1, 1, 12'h000, 1'($urandom), 1'($urandom), 0);
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule